// File: doc/BRIEF.md
# Reset Cause Status Register

This block is an 8-bit control and status register that a small microcontroller core uses to find out why it last came out of reset. Single-cycle event pulses from the rest of the chip clear or set individual flags. The events are power-on, brown-out, a reset instruction, watchdog expiry, watchdog clear and sleep entry. Firmware reads the register and re-arms the sticky flags through a one-cycle write port. The block also holds an interrupt-priority enable and a software brown-out enable.

A 2-bit brown-out configuration input decides whether the software brown-out enable has any effect, and the block drives the resulting brown-out enable to the detector. A decoded output reports that the last reset came from a brown-out rather than from power-up. An event pulse or a write sampled at a clock edge shows in `reg_q` right after that edge. The synchronous reset `rst` and a power-on event both put the register into its power-up state.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst`, the stored bits hold 0x5C, listed from bit 7 down to bit 0. These are priority enable 0, software brown-out enable 1, unused bit 5 at 0, reset-instruction flag 1, watchdog flag 1, power-down flag 1, power-on flag 0 and brown-out flag 0. `reg_q` reads 0x5C when `bor_cfg`=01 and 0x1C otherwise. Bit 5 always reads 0.
- R2: Bit 7 (priority enable) takes `wr_data[7]` on a write, and `prio_en` equals it.
- R3: Bit 3 (watchdog flag) becomes 0 on `ev_wdt_expire`. It becomes 1 on `ev_wdt_clear` or `ev_sleep`. When expiry and clear/sleep arrive together, it becomes 0.
- R4: Bit 2 (power-down flag) becomes 0 on `ev_sleep` and becomes 1 on `ev_wdt_clear`. When both arrive together, it becomes 0.
- R5: Writes never change bits 5, 3 and 2.
- R6: Bit 4 (reset-instruction flag) becomes 0 on `ev_rst_instr`. A write is the only way it returns to 1.
- R7: Bit 1 (power-on flag) becomes 0 on `ev_por`, and bit 0 (brown-out flag) becomes 0 on `ev_bor`. Writes take `wr_data[1]` and `wr_data[0]`.
- R8: `bor_cause` is 1 exactly when bit 0 is 0 and bit 1 is 1.
- R9: Bit 6 (software brown-out enable) is written and read only while `bor_cfg`=01. Under any other setting it reads 0, writes leave the stored value unchanged, and that stored value shows again when the setting returns to 01.
- R10: `bor_en_eff` is 1 when `bor_cfg`=11. It equals bit 6 when `bor_cfg`=01. It is 0 when `bor_cfg` is 00 or 10.
- R11: When an event and a write hit the same flag in the same cycle, the event wins.
- R12: `ev_por` returns every stored bit to the R1 values and overrides any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the power-up state |
| ev_por | input | 1 | Power-on event pulse |
| ev_bor | input | 1 | Brown-out event pulse |
| ev_rst_instr | input | 1 | Reset-instruction event pulse |
| ev_wdt_expire | input | 1 | Watchdog expiry pulse |
| ev_wdt_clear | input | 1 | Watchdog clear pulse |
| ev_sleep | input | 1 | Sleep entry pulse |
| bor_cfg | input | 2 | Brown-out configuration setting |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| reg_q | output | 8 | Register read value |
| prio_en | output | 1 | Interrupt priority enable |
| bor_en_eff | output | 1 | Effective brown-out detector enable |
| bor_cause | output | 1 | Last reset was a brown-out |

## Verification
Directed sequences apply each event alone, then in the conflicting pairs (expiry with clear, sleep with clear, event with a write to the same bit, power-on with a full write). These pairs separate the priority orderings from one another. All-ones and all-zeros writes show which bits are writable. Switching `bor_cfg` through all four settings between writes tells apart a hidden stored value, an ignored write and the detector enable decode. A long run of sparse random events and writes then catches interactions that the directed cases do not reach.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int REG_W = 8;

  localparam int IDX_PRIO  = 7;
  localparam int IDX_SWBOR = 6;
  localparam int IDX_SPARE = 5;
  localparam int IDX_RI    = 4;
  localparam int IDX_TO    = 3;
  localparam int IDX_PD    = 2;
  localparam int IDX_POR   = 1;
  localparam int IDX_BOR   = 0;

  // power-up contents of the stored bits
  localparam logic [REG_W-1:0] PWRUP_VAL = 8'h5C;
  // bits the write port may touch (bit 6 further gated by configuration)
  localparam logic [REG_W-1:0] WR_MASK   = 8'hD3;

  typedef enum logic [1:0] {
    BCFG_OFF = 2'b00,
    BCFG_SW  = 2'b01,
    BCFG_ALT = 2'b10,
    BCFG_ON  = 2'b11
  } bcfg_e;
endpackage

// File: rtl/rcs_flag_cell.sv
module rcs_flag_cell #(
  parameter logic INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic init,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  // priority: init > hardware clear > hardware set > write
  always_ff @(posedge clk) begin
    if (init)        q <= INIT_VAL;
    else if (hw_clr) q <= 1'b0;
    else if (hw_set) q <= 1'b1;
    else if (wr_en)  q <= wr_bit;
  end
endmodule

// File: rtl/rcs_event_map.sv
module rcs_event_map
  import rcs_pkg::*;
(
  input  logic             ev_bor,
  input  logic             ev_rst_instr,
  input  logic             ev_wdt_expire,
  input  logic             ev_wdt_clear,
  input  logic             ev_sleep,
  output logic [REG_W-1:0] set_v,
  output logic [REG_W-1:0] clr_v
);
  always_comb begin
    set_v = '0;
    clr_v = '0;
    clr_v[IDX_RI]  = ev_rst_instr;
    clr_v[IDX_TO]  = ev_wdt_expire;
    set_v[IDX_TO]  = ev_wdt_clear | ev_sleep;
    clr_v[IDX_PD]  = ev_sleep;
    set_v[IDX_PD]  = ev_wdt_clear;
    clr_v[IDX_BOR] = ev_bor;
  end
endmodule

// File: rtl/rcs_bor_ctrl.sv
module rcs_bor_ctrl
  import rcs_pkg::*;
(
  input  logic [1:0] bor_cfg,
  input  logic       sw_bit,
  output logic       sw_active,
  output logic       bor_en_eff
);
  bcfg_e cfg;
  assign cfg = bcfg_e'(bor_cfg);

  always_comb begin
    sw_active  = 1'b0;
    bor_en_eff = 1'b0;
    case (cfg)
      BCFG_SW: begin
        sw_active  = 1'b1;
        bor_en_eff = sw_bit;
      end
      BCFG_ON:  bor_en_eff = 1'b1;
      default:  bor_en_eff = 1'b0;
    endcase
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_por,
  input  logic             ev_bor,
  input  logic             ev_rst_instr,
  input  logic             ev_wdt_expire,
  input  logic             ev_wdt_clear,
  input  logic             ev_sleep,
  input  logic [1:0]       bor_cfg,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] reg_q,
  output logic             prio_en,
  output logic             bor_en_eff,
  output logic             bor_cause
);
  logic             init;
  logic [REG_W-1:0] set_v, clr_v, wr_v, rd_mask, state;
  logic             sw_active;

  assign init = rst | ev_por;

  rcs_event_map u_map (
    .ev_bor       (ev_bor),
    .ev_rst_instr (ev_rst_instr),
    .ev_wdt_expire(ev_wdt_expire),
    .ev_wdt_clear (ev_wdt_clear),
    .ev_sleep     (ev_sleep),
    .set_v        (set_v),
    .clr_v        (clr_v)
  );

  rcs_bor_ctrl u_bor (
    .bor_cfg   (bor_cfg),
    .sw_bit    (state[IDX_SWBOR]),
    .sw_active (sw_active),
    .bor_en_eff(bor_en_eff)
  );

  always_comb begin
    wr_v             = WR_MASK & {REG_W{wr_en}};
    wr_v[IDX_SWBOR]  = wr_en & sw_active;
    rd_mask          = '1;
    rd_mask[IDX_SPARE] = 1'b0;
    rd_mask[IDX_SWBOR] = sw_active;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    rcs_flag_cell #(.INIT_VAL(PWRUP_VAL[i])) u_cell (
      .clk   (clk),
      .init  (init),
      .hw_set(set_v[i]),
      .hw_clr(clr_v[i]),
      .wr_en (wr_v[i]),
      .wr_bit(wr_data[i]),
      .q     (state[i])
    );
  end

  assign reg_q     = state & rd_mask;
  assign prio_en   = state[IDX_PRIO];
  assign bor_cause = ~state[IDX_BOR] & state[IDX_POR];

  AST_TO_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    (ev_wdt_expire && !ev_por) |=> !reg_q[IDX_TO]); // R3
  AST_PD_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (ev_sleep && !ev_por) |=> !reg_q[IDX_PD]); // R4
  AST_RO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev_por && !ev_wdt_expire && !ev_wdt_clear && !ev_sleep) |=> $stable(reg_q[IDX_TO:IDX_PD])); // R5
  AST_RI_CLR: assert property (@(posedge clk) disable iff (rst)
    (ev_rst_instr && !ev_por) |=> !reg_q[IDX_RI]); // R6
  AST_SW_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (bor_cfg != 2'b01) |-> !reg_q[IDX_SWBOR]); // R9
  AST_EN_FORCED: assert property (@(posedge clk) disable iff (rst)
    (bor_cfg == 2'b11) |-> bor_en_eff); // R10
  AST_POR_INIT: assert property (@(posedge clk) disable iff (rst)
    ev_por |=> (reg_q[4:0] == 5'b11100 && !prio_en)); // R12
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_q[IDX_SPARE]); // R1
endmodule

// File: tb/rst_cause_reg_tb.sv
`timescale 1ns/1ps
module rst_cause_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_por = 0, ev_bor = 0, ev_rst_instr = 0;
  logic       ev_wdt_expire = 0, ev_wdt_clear = 0, ev_sleep = 0;
  logic [1:0] bor_cfg = 2'b01;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] reg_q;
  logic       prio_en, bor_en_eff, bor_cause;

  int n_chk = 0, n_bad = 0;

  // reference state
  bit m_prio, m_sw, m_ri, m_to, m_pd, m_po, m_bo;

  always #2.5 clk = ~clk;

  rst_cause_reg dut_i (
    .clk(clk), .rst(rst), .ev_por(ev_por), .ev_bor(ev_bor),
    .ev_rst_instr(ev_rst_instr), .ev_wdt_expire(ev_wdt_expire),
    .ev_wdt_clear(ev_wdt_clear), .ev_sleep(ev_sleep), .bor_cfg(bor_cfg),
    .wr_en(wr_en), .wr_data(wr_data), .reg_q(reg_q), .prio_en(prio_en),
    .bor_en_eff(bor_en_eff), .bor_cause(bor_cause)
  );

  localparam logic [5:0] E_POR = 6'b100000, E_BOR = 6'b010000, E_RI = 6'b001000,
                         E_EXP = 6'b000100, E_CLR = 6'b000010, E_SLP = 6'b000001,
                         E_NONE = 6'b0;

  task automatic model_edge();
    if (rst || ev_por) begin
      m_prio = 0; m_sw = 1; m_ri = 1; m_to = 1; m_pd = 1; m_po = 0; m_bo = 0;
    end else begin
      if (wr_en) begin
        m_prio = wr_data[7];
        if (bor_cfg == 2'b01) m_sw = wr_data[6];
        m_ri = wr_data[4];
        m_po = wr_data[1];
        m_bo = wr_data[0];
      end
      if (ev_rst_instr) m_ri = 0;
      if (ev_bor) m_bo = 0;
      if (ev_wdt_clear || ev_sleep) m_to = 1;
      if (ev_wdt_expire) m_to = 0;
      if (ev_wdt_clear) m_pd = 1;
      if (ev_sleep) m_pd = 0;
    end
  endtask

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] e_q;
    logic e_en;
    e_q = {m_prio, (bor_cfg == 2'b01) ? m_sw : 1'b0, 1'b0, m_ri, m_to, m_pd, m_po, m_bo};
    e_en = (bor_cfg == 2'b11) ? 1'b1 : (bor_cfg == 2'b01) ? m_sw : 1'b0;
    cmp(tag, reg_q, e_q, "reg_q");
    cmp(tag, {7'b0, prio_en}, {7'b0, m_prio}, "prio_en");
    cmp(tag, {7'b0, bor_en_eff}, {7'b0, e_en}, "bor_en_eff");
    cmp(tag, {7'b0, bor_cause}, {7'b0, (!m_bo && m_po)}, "bor_cause");
  endtask

  // called at a falling edge; applies stimulus for one rising edge, then compares
  task automatic step(input string tag, input logic [5:0] ev, input logic we, input logic [7:0] d);
    {ev_por, ev_bor, ev_rst_instr, ev_wdt_expire, ev_wdt_clear, ev_sleep} = ev;
    wr_en = we; wr_data = d;
    @(posedge clk);
    model_edge();
    #1;
    compare_all(tag);
    @(negedge clk);
  endtask

  task automatic set_cfg(input string tag, input logic [1:0] c);
    bor_cfg = c;
    #1;
    compare_all(tag);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1;
    step("R1", E_NONE, 0, 8'h00);
    step("R1", E_NONE, 0, 8'h00);
    rst = 0;
    step("R1", E_NONE, 0, 8'h00);
    set_cfg("R1", 2'b00);
    set_cfg("R1", 2'b01);
    // priority enable
    step("R2", E_NONE, 1, 8'h80 | 8'h13);
    step("R2", E_NONE, 1, 8'h40 | 8'h13);
    // watchdog flag
    step("R3", E_EXP, 0, 8'h00);
    step("R3", E_CLR, 0, 8'h00);
    step("R3", E_EXP | E_CLR, 0, 8'h00);
    step("R3", E_SLP, 0, 8'h00);
    step("R3", E_EXP | E_SLP, 0, 8'h00);
    // power-down flag
    step("R4", E_CLR, 0, 8'h00);
    step("R4", E_SLP, 0, 8'h00);
    step("R4", E_CLR | E_SLP, 0, 8'h00);
    // read-only bits
    step("R5", E_EXP, 0, 8'h00);
    step("R5", E_NONE, 1, 8'hFF);
    step("R5", E_CLR, 0, 8'h00);
    step("R5", E_NONE, 1, 8'h00);
    // reset instruction flag
    step("R6", E_RI, 0, 8'h00);
    step("R6", E_NONE, 0, 8'h00);
    step("R6", E_NONE, 1, 8'h50);
    step("R11", E_RI, 1, 8'h50);
    // power-on / brown-out flags and cause
    step("R7", E_NONE, 1, 8'h53);
    step("R8", E_BOR, 0, 8'h00);
    step("R11", E_BOR, 1, 8'h53);
    step("R8", E_NONE, 1, 8'h53);
    step("R8", E_NONE, 1, 8'h51);
    step("R7", E_POR, 0, 8'h00);
    step("R8", E_NONE, 1, 8'h52);
    // software brown-out enable
    step("R9", E_NONE, 1, 8'h12);
    set_cfg("R10", 2'b11);
    set_cfg("R10", 2'b10);
    step("R9", E_NONE, 1, 8'h52);
    set_cfg("R9", 2'b01);
    step("R10", E_NONE, 1, 8'h52);
    set_cfg("R10", 2'b00);
    step("R9", E_NONE, 1, 8'h12);
    set_cfg("R9", 2'b01);
    // power-on overrides a full write
    step("R12", E_SLP | E_EXP | E_RI, 0, 8'h00);
    step("R12", E_POR | E_CLR, 1, 8'hFF);
    // sparse random mix
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] ev;
      ev = '0;
      if ($urandom_range(63) == 0) ev[5] = 1'b1;
      for (int b = 0; b < 5; b++)
        if ($urandom_range(7) == 0) ev[b] = 1'b1;
      if ($urandom_range(15) == 0) bor_cfg = 2'($urandom_range(3));
      step("R11", ev, ($urandom_range(3) == 0), 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule